// File: doc/BRIEF.md
# Coincidence Tag Lookup Correlator

This block finds interesting hit pairs between two stacked strip layers. For one bank position it takes a 16-bit word carrying two inner-layer cluster codes, plus three outer-layer cluster codes taken from the neighbouring positions n-1, n and n+1. Each inner cluster is paired with each of the three outer clusters, which gives six pairs. Each pair is folded into an address in a programmable tag memory. The six lookups run one per clock in a fixed order. A location either holds an 11-bit tag or is empty. An empty location means the pair is of no interest.

A crossing starts with a one-cycle strobe. The block then runs on its own, and emits at most one 16-bit stub for that crossing. The stub joins the first matching tag with a 5-bit position identifier. Further hits in the same crossing are not sent. They add to a saturating excess-hit count instead. Before operation, the tag memory is loaded through a plain address, data and write-enable port.

Top module: `coincidence_correlator`

## Requirements
- R1: After reset, `stubValid` is 0, `ovfCount` is 0 and every tag memory entry is empty.
- R2: Lookup k (k = 0..5) pairs inner cluster k/3 with outer code k%3, where outer 0 is `outerPrev`, 1 is `outerCur` and 2 is `outerNext`. Inner cluster 0 is `innerWord[15:8]` and inner cluster 1 is `innerWord[7:0]`. The 16-bit pair code is {inner, outer}. The memory address is pair[9:0] XOR pair[15:10], so two pairs with the same folded address share one entry.
- R3: A crossing with at least one hit gives a stub with `stubWord[15:11]` equal to `posId` (latched at the start strobe) and `stubWord[10:0]` equal to the tag.
- R4: A crossing in which no lookup finds a valid entry gives no stub.
- R5: A pair in which either cluster code is 8'hFF is not looked up and can never hit, even when its folded address holds a valid entry.
- R6: When several lookups hit, the stub carries the tag of the lowest-numbered lookup.
- R7: `ovfCount` grows by (hits - 1) at the end of each crossing with hits, saturates at its all-ones value, and changes at no other time.
- R8: `stubValid` is a one-cycle pulse high after the 8th rising edge counted from the edge that samples `xingStart`. A start strobe that arrives within the 7 edges after an accepted start is ignored.
- R9: A write with `memValid`=1 stores `memTag` at `memAddr`. A write with `memValid`=0 empties that entry. Later crossings see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xingStart | input | 1 | One-cycle strobe that starts a crossing |
| innerWord | input | 16 | Two inner cluster codes, cluster 0 in the upper byte |
| outerPrev | input | 8 | Outer cluster code at position n-1 |
| outerCur | input | 8 | Outer cluster code at position n |
| outerNext | input | 8 | Outer cluster code at position n+1 |
| posId | input | 5 | Bank position identifier placed in the stub |
| memWe | input | 1 | Tag memory write enable |
| memAddr | input | 10 | Tag memory write address |
| memValid | input | 1 | Entry holds a tag (1) or is empty (0) |
| memTag | input | 11 | Tag value to store |
| stubValid | output | 1 | Stub present this cycle |
| stubWord | output | 16 | {position identifier, tag} |
| ovfCount | output | 8 | Saturating count of suppressed extra hits |

## Verification
Single programmed pairs are placed on different lookups to show the pairing order. The inner bytes and the outer codes are then swapped, which separates the cluster-to-lookup map from the address fold. Two entries that fold onto the same address show the aliasing rule. Crossings with two or six hits tell the first-hit choice apart from the excess count, and a run of six-hit crossings drives the count into saturation. Null codes are placed over programmed entries. The bench also sends strobes that overlap a busy crossing and strobes that fall exactly on the first free edge, to separate ignored starts from accepted ones.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int INNER_N   = 2;
  localparam int OUTER_N   = 3;
  localparam int NUM_TESTS = INNER_N * OUTER_N;
  localparam int TEST_W    = $clog2(NUM_TESTS);

  typedef struct packed {
    logic              latchIn;
    logic              issue;
    logic [TEST_W-1:0] testSel;
    logic              evalEn;
    logic              finalize;
  } strobes_t;
endpackage

// File: rtl/corr_tagmem.sv
module corr_tagmem #(
  parameter int AW    = 10,
  parameter int TAG_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic             wrValid,
  input  logic [TAG_W-1:0] wrTag,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic             rdValid,
  output logic [TAG_W-1:0] rdTag
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] validBits;
  logic [TAG_W-1:0] tagArr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) validBits <= '0;
    else if (wrEn) validBits[wrAddr] <= wrValid;
  end

  always_ff @(posedge clk) begin
    if (wrEn) tagArr[wrAddr] <= wrTag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdTag   <= '0;
    end else if (rdEn) begin
      rdValid <= validBits[rdAddr];
      rdTag   <= tagArr[rdAddr];
    end else begin
      rdValid <= 1'b0;
    end
  end
endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     xingStart,
  output strobes_t strobes
);
  localparam int PH_W = $clog2(NUM_TESTS + 2);

  logic [PH_W-1:0] phase;

  always_comb begin
    strobes          = '0;
    strobes.latchIn  = (phase == '0) && xingStart;
    strobes.issue    = (phase >= PH_W'(1)) && (phase <= PH_W'(NUM_TESTS));
    strobes.testSel  = TEST_W'(phase - PH_W'(1));
    strobes.evalEn   = (phase >= PH_W'(2)) && (phase <= PH_W'(NUM_TESTS + 1));
    strobes.finalize = (phase == PH_W'(NUM_TESTS + 1));
  end

  always_ff @(posedge clk) begin
    if (rst)                   phase <= '0;
    else if (strobes.latchIn)  phase <= PH_W'(1);
    else if (strobes.finalize) phase <= '0;
    else if (phase != '0)      phase <= phase + PH_W'(1);
  end

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    (phase != '0) |=> (phase != PH_W'(1))); // R8
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int CLU_W  = 8,
  parameter int TAG_W  = 11,
  parameter int POS_W  = 5,
  parameter int MEM_AW = 10,
  parameter int OVF_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobes_t                 strobes,
  input  logic [INNER_N*CLU_W-1:0] innerWord,
  input  logic [CLU_W-1:0]         outerPrev,
  input  logic [CLU_W-1:0]         outerCur,
  input  logic [CLU_W-1:0]         outerNext,
  input  logic [POS_W-1:0]         posId,
  input  logic                     memWe,
  input  logic [MEM_AW-1:0]        memAddr,
  input  logic                     memValid,
  input  logic [TAG_W-1:0]         memTag,
  output logic                     stubValid,
  output logic [TAG_W+POS_W-1:0]   stubWord,
  output logic [OVF_W-1:0]         ovfCount
);
  localparam int PAIR_W = 2 * CLU_W;
  localparam int HIT_W  = $clog2(NUM_TESTS + 1);
  localparam logic [CLU_W-1:0] NULL_CODE = '1;

  logic [INNER_N-1:0][CLU_W-1:0] innerReg;
  logic [OUTER_N-1:0][CLU_W-1:0] outerReg;
  logic [POS_W-1:0]  posReg;
  logic [TEST_W-1:0] innerIdx, outerIdx;
  logic [CLU_W-1:0]  curInner, curOuter;
  logic [PAIR_W-1:0] pairCode;
  logic [MEM_AW-1:0] rdAddr;
  logic              nullPair, rdEn;
  logic              memRdValid;
  logic [TAG_W-1:0]  memRdTag;
  logic              hitNow, found;
  logic [TAG_W-1:0]  firstTag;
  logic [HIT_W-1:0]  hitCnt, totalHits, extraHits;
  logic [OVF_W:0]    ovfWide;
  logic [OVF_W-1:0]  ovfNext;

  // lookup order: inner cluster major, outer position minor
  always_comb begin
    innerIdx = TEST_W'(strobes.testSel / TEST_W'(OUTER_N));
    outerIdx = TEST_W'(strobes.testSel % TEST_W'(OUTER_N));
    curInner = '0;
    curOuter = '0;
    for (int i = 0; i < INNER_N; i++)
      if (innerIdx == TEST_W'(i)) curInner = innerReg[i];
    for (int j = 0; j < OUTER_N; j++)
      if (outerIdx == TEST_W'(j)) curOuter = outerReg[j];
  end

  assign pairCode = {curInner, curOuter};

  generate
    if (MEM_AW >= PAIR_W) begin : gDirect
      assign rdAddr = MEM_AW'(pairCode);
    end else begin : gFold
      assign rdAddr = pairCode[MEM_AW-1:0] ^ MEM_AW'(pairCode >> MEM_AW);
    end
  endgenerate

  assign nullPair = (curInner == NULL_CODE) || (curOuter == NULL_CODE);
  assign rdEn     = strobes.issue && !nullPair;

  corr_tagmem #(.AW(MEM_AW), .TAG_W(TAG_W)) uMem (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (memWe),
    .wrAddr (memAddr),
    .wrValid(memValid),
    .wrTag  (memTag),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .rdValid(memRdValid),
    .rdTag  (memRdTag)
  );

  assign hitNow    = strobes.evalEn && memRdValid;
  assign totalHits = HIT_W'(hitCnt + HIT_W'(hitNow));
  assign extraHits = (totalHits == '0) ? '0 : HIT_W'(totalHits - HIT_W'(1));
  assign ovfWide   = {1'b0, ovfCount} + (OVF_W+1)'(extraHits);
  assign ovfNext   = ovfWide[OVF_W] ? '1 : ovfWide[OVF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      innerReg  <= '0;
      outerReg  <= '0;
      posReg    <= '0;
      found     <= 1'b0;
      firstTag  <= '0;
      hitCnt    <= '0;
      stubValid <= 1'b0;
      stubWord  <= '0;
      ovfCount  <= '0;
    end else begin
      stubValid <= 1'b0;
      if (strobes.latchIn) begin
        for (int i = 0; i < INNER_N; i++)
          innerReg[i] <= innerWord[(INNER_N-1-i)*CLU_W +: CLU_W];
        outerReg <= {outerNext, outerCur, outerPrev};
        posReg   <= posId;
        found    <= 1'b0;
        hitCnt   <= '0;
      end
      if (hitNow) begin
        hitCnt <= totalHits;
        if (!found) begin
          found    <= 1'b1;
          firstTag <= memRdTag;
        end
      end
      if (strobes.finalize) begin
        stubValid <= found || hitNow;
        stubWord  <= {posReg, (found ? firstTag : memRdTag)};
        ovfCount  <= ovfNext;
      end
    end
  end

  AST_NULL_SKIP: assert property (@(posedge clk) disable iff (rst)
    (strobes.issue && nullPair) |=> !memRdValid); // R5
  AST_STUB_AT_END: assert property (@(posedge clk) disable iff (rst)
    stubValid |-> $past(strobes.finalize)); // R8
  AST_STUB_PULSE: assert property (@(posedge clk) disable iff (rst)
    stubValid |=> !stubValid); // R8
  AST_OVF_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovfCount) |-> $past(strobes.finalize)); // R7
  AST_OVF_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    ovfCount >= $past(ovfCount)); // R7
endmodule

// File: rtl/coincidence_correlator.sv
module coincidence_correlator
  import corr_pkg::*;
#(
  parameter int CLU_W  = 8,
  parameter int TAG_W  = 11,
  parameter int POS_W  = 5,
  parameter int MEM_AW = 10,
  parameter int OVF_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     xingStart,
  input  logic [INNER_N*CLU_W-1:0] innerWord,
  input  logic [CLU_W-1:0]         outerPrev,
  input  logic [CLU_W-1:0]         outerCur,
  input  logic [CLU_W-1:0]         outerNext,
  input  logic [POS_W-1:0]         posId,
  input  logic                     memWe,
  input  logic [MEM_AW-1:0]        memAddr,
  input  logic                     memValid,
  input  logic [TAG_W-1:0]         memTag,
  output logic                     stubValid,
  output logic [TAG_W+POS_W-1:0]   stubWord,
  output logic [OVF_W-1:0]         ovfCount
);
  strobes_t strobes;

  corr_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .xingStart(xingStart),
    .strobes  (strobes)
  );

  corr_datapath #(
    .CLU_W(CLU_W), .TAG_W(TAG_W), .POS_W(POS_W), .MEM_AW(MEM_AW), .OVF_W(OVF_W)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .innerWord(innerWord),
    .outerPrev(outerPrev),
    .outerCur (outerCur),
    .outerNext(outerNext),
    .posId    (posId),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memValid (memValid),
    .memTag   (memTag),
    .stubValid(stubValid),
    .stubWord (stubWord),
    .ovfCount (ovfCount)
  );
endmodule

// File: tb/tb_coincidence_correlator.sv
`timescale 1ns/1ps
module tb_coincidence_correlator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xingStart = 1'b0;
  logic [15:0] innerWord = '0;
  logic [7:0]  outerPrev = '0, outerCur = '0, outerNext = '0;
  logic [4:0]  posId = '0;
  logic        memWe = 1'b0;
  logic [9:0]  memAddr = '0;
  logic        memValid = 1'b0;
  logic [10:0] memTag = '0;
  logic        stubValid;
  logic [15:0] stubWord;
  logic [7:0]  ovfCount;

  coincidence_correlator dut (
    .clk(clk), .rst(rst), .xingStart(xingStart), .innerWord(innerWord),
    .outerPrev(outerPrev), .outerCur(outerCur), .outerNext(outerNext),
    .posId(posId), .memWe(memWe), .memAddr(memAddr), .memValid(memValid),
    .memTag(memTag), .stubValid(stubValid), .stubWord(stubWord), .ovfCount(ovfCount)
  );

  always #2 clk = ~clk;

  // behavioural reference state
  bit    refValid [1024];
  int    refTag   [1024];
  int    negCnt = 0;
  int    lastAccept = -100;
  int    expAt = -1;
  bit    expHit = 0;
  int    expWord = 0;
  int    expOvf = 0;
  int    pendOvf = 0;
  string curReq = "R1";
  int    checks = 0;
  int    errors = 0;
  int    idx;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int addrOf(int inC, int ouC);
    int pair;
    pair = inC * 256 + ouC;
    return (pair & 1023) ^ (pair >> 10);
  endfunction

  // compared on every falling edge
  always @(negedge clk) begin
    idx = negCnt + 1;
    if (idx == expAt) expOvf = pendOvf;
    chk({curReq, " stubValid"}, {31'b0, stubValid}, {31'b0, (idx == expAt) && expHit});
    if (idx == expAt && expHit) chk({curReq, " stubWord"}, {16'b0, stubWord}, expWord);
    chk("R7 ovfCount", {24'b0, ovfCount}, expOvf);
    negCnt = idx;
  end

  task automatic wr(int addr, bit v, int tag);
    @(negedge clk); #1;
    memWe = 1'b1; memAddr = addr[9:0]; memValid = v; memTag = tag[10:0];
    @(negedge clk); #1;
    memWe = 1'b0;
    refValid[addr] = v;
    refTag[addr]   = tag;
  endtask

  task automatic prog(int inC, int ouC, int tag);
    wr(addrOf(inC, ouC), 1'b1, tag);
  endtask

  task automatic crossing(string req, logic [15:0] inW, logic [7:0] op,
                          logic [7:0] oc, logic [7:0] on, logic [4:0] pid);
    int k, total, first, inC, ouC, a;
    @(negedge clk); #1;
    innerWord = inW; outerPrev = op; outerCur = oc; outerNext = on;
    posId = pid; xingStart = 1'b1;
    k = negCnt;
    if (k >= lastAccept + 8) begin
      lastAccept = k;
      curReq = req;
      total = 0;
      first = -1;
      for (int t = 0; t < 6; t++) begin
        inC = (t < 3) ? int'(inW[15:8]) : int'(inW[7:0]);
        ouC = (t % 3 == 0) ? int'(op) : ((t % 3 == 1) ? int'(oc) : int'(on));
        if (inC != 255 && ouC != 255) begin
          a = addrOf(inC, ouC);
          if (refValid[a]) begin
            total++;
            if (first < 0) first = refTag[a];
          end
        end
      end
      expHit  = (total > 0);
      expWord = (int'(pid) << 11) | (first & 2047);
      pendOvf = (total > 0) ? expOvf + total - 1 : expOvf;
      if (pendOvf > 255) pendOvf = 255;
      expAt = k + 8;
    end
    @(negedge clk); #1;
    xingStart = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1: memory empty after reset
    crossing("R1 empty", 16'h2425, 8'h10, 8'h11, 8'h12, 5'd3); waitIdle();
    // R2/R3: single hit on lookup 2 (inner0 vs next)
    prog(8'h24, 8'h12, 11'h101);
    crossing("R2 lookup2", 16'h2440, 8'h10, 8'h11, 8'h12, 5'd5); waitIdle();
    crossing("R3 stub fields", 16'h2440, 8'h10, 8'h11, 8'h12, 5'd9); waitIdle();
    // R6: lookups 2 and 3 both hit
    prog(8'h40, 8'h10, 11'h202);
    crossing("R6 first wins", 16'h2440, 8'h10, 8'h11, 8'h12, 5'd1); waitIdle();
    // R2: swapped inner bytes -> lookup 0 hits first
    crossing("R2 inner swap", 16'h4024, 8'h10, 8'h11, 8'h12, 5'd2); waitIdle();
    // R2: swapped outer codes
    crossing("R2 outer swap", 16'h2440, 8'h12, 8'h11, 8'h10, 5'd4); waitIdle();
    // R4: no entry
    crossing("R4 miss", 16'h3333, 8'h10, 8'h11, 8'h12, 5'd6); waitIdle();
    // R5: null codes over programmed entries
    prog(8'hFF, 8'h11, 11'h3AA);
    prog(8'h55, 8'hFF, 11'h3BB);
    crossing("R5 null skip", 16'hFF55, 8'h20, 8'h11, 8'hFF, 5'd7); waitIdle();
    prog(8'h55, 8'h10, 11'h0C3);
    crossing("R5 non-null still hits", 16'hFF55, 8'h10, 8'h11, 8'hFF, 5'd8); waitIdle();
    // R2: folded address aliasing (C8,07) and (00,35)
    prog(8'hC8, 8'h07, 11'h155);
    crossing("R2 fold direct", 16'hC833, 8'h01, 8'h07, 8'h02, 5'd10); waitIdle();
    crossing("R2 fold alias", 16'h0033, 8'h35, 8'h01, 8'h02, 5'd11); waitIdle();
    // R8: overlapping start ignored, start on first free edge accepted
    crossing("R8 busy first", 16'h2440, 8'h10, 8'h11, 8'h12, 5'd12);
    crossing("R8 ignored", 16'h4024, 8'h10, 8'h11, 8'h12, 5'd13);
    repeat (5) @(negedge clk);
    crossing("R8 back to back", 16'h4024, 8'h10, 8'h11, 8'h12, 5'd14); waitIdle();
    // R9: empty an entry, then overwrite another
    wr(addrOf(8'h24, 8'h12), 1'b0, 0);
    crossing("R9 cleared", 16'h2440, 8'h10, 8'h11, 8'h12, 5'd15); waitIdle();
    prog(8'h40, 8'h10, 11'h7FF);
    crossing("R9 rewritten", 16'h2440, 8'h10, 8'h11, 8'h12, 5'd31); waitIdle();
    // R7: six hits per crossing until saturation
    prog(8'h66, 8'h77, 11'h0AB);
    for (int n = 0; n < 54; n++) begin
      crossing("R7 saturate", 16'h6666, 8'h77, 8'h77, 8'h77, 5'd16);
      waitIdle();
    end
    waitIdle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule